// File: doc/BRIEF.md
# Exclusive Doubleword Store Unit

This unit executes one store-release-exclusive of a 64-bit value held in two 32-bit registers. An instruction word arrives on a valid/ready request port. It can be in a 32-bit fixed-width encoding or in a two-halfword encoding. The unit decodes the word and checks that its register choices are legal. It reads the base register and both data registers through a combinational register-file read port. It then uses an external exclusive-monitor verdict to choose the outcome. It either issues a single 8-byte write or skips it, and it reports a status of 0 (stored) or 1 (not stored) for the destination register.

The unit processes one instruction at a time. `req_ready` is high only while the unit is idle. A request is accepted in the cycle where `req_valid` and `req_ready` are both high. In that same cycle the register-file read data, `mon_pass`, `req_cond_pass` and `req_big_endian` must be valid. The memory write port follows valid/ready rules: once `mem_wvalid` rises, it stays high with stable address and data until the cycle in which `mem_wready` is high. The unit then waits for one `mem_bvalid` cycle, which may carry `mem_babort`. Completion is marked by a one-cycle `done` pulse. Any fault flag appears only in the same cycle as `done`. The `done` pulse is also the point at which a surrounding pipeline may apply release ordering.

Top module: `xstore_dw_unit`

## Requirements
- R1: With `req_pair_enc`=0, the word is accepted as this instruction only if all of the following hold: bits 31:28 are not 4'hF, bits 27:20 equal 8'h1A, bits 9:8 equal 2'b10 and bits 7:4 equal 4'b1001. Bits 11:10 are not checked. The fields are base = bits 19:16, destination = bits 15:12 and first data register = bits 3:0; the second data register is first+1. Any other word raises `undef_instr`.
- R2: With `req_pair_enc`=1, the first halfword is `req_instr[31:16]`, with 12'hE8C in bits 31:20 and the base in bits 19:16. The second halfword is `req_instr[15:0]`, with the first data register in bits 15:12, the second in bits 11:8, 4'hF in bits 7:4 and the destination in bits 3:0. A mismatch in either fixed part raises `undef_instr`.
- R3: In the fixed-width form, the instruction is illegal if the first data register is odd, if it is 14, if the destination is 15, or if the base is 15.
- R4: In the two-halfword form, the instruction is illegal if any of the four register fields is 15. In both forms it is illegal if the destination equals the base or either data register. Two equal data registers are legal.
- R5: An illegal or unrecognised word completes with `undef_instr` high together with `done`. No memory write and no destination write-back occur.
- R6: The write address is the base register value. In little-endian mode (`req_big_endian`=0), `mem_wdata` is {second, first}. In big-endian mode it is {first, second}, so the first register always lands at the base address.
- R7: If the monitor passes and the base is word-aligned, one write is issued and the destination later receives 0. If the monitor fails, no write is issued and the destination receives 1. Status bits 31:1 are always zero.
- R8: A base with non-zero bits 1:0 and a passing monitor completes with `align_fault`, with no write and no write-back. A misaligned base with a failing monitor raises no fault and writes back status 1.
- R9: A response with `mem_babort` high completes with `data_abort` and no destination write-back.
- R10: With `req_cond_pass` low, the instruction completes with `done` in the cycle after acceptance. It raises no flag, makes no write and does no write-back, even if the word is illegal.
- R11: While `mem_wvalid` is high and `mem_wready` is low, the address and data hold steady. `req_ready` is high only when the unit is idle, and is high after reset.
- R12: On the write path, `wb_valid` is high in the cycle after the `mem_bvalid` cycle. On the monitor-fail path, `wb_valid` is high in the cycle after acceptance. `done` follows `wb_valid` by exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Instruction offered |
| req_ready | output | 1 | Unit idle and able to accept |
| req_instr | input | 32 | Instruction word |
| req_pair_enc | input | 1 | 1 selects the two-halfword encoding |
| req_cond_pass | input | 1 | Condition check result for this instruction |
| req_big_endian | input | 1 | 1 selects big-endian packing |
| rf_base_idx | output | 4 | Register-file read index for the base |
| rf_lo_idx | output | 4 | Read index for the first data register |
| rf_hi_idx | output | 4 | Read index for the second data register |
| rf_base_data | input | WORD_W | Base register value |
| rf_lo_data | input | WORD_W | First data register value |
| rf_hi_data | input | WORD_W | Second data register value |
| mon_pass | input | 1 | Exclusive-monitor verdict for this access |
| mem_wvalid | output | 1 | Write request valid |
| mem_wready | input | 1 | Write request accepted |
| mem_waddr | output | WORD_W | Write byte address |
| mem_wdata | output | 2*WORD_W | Write data, 8 bytes |
| mem_bvalid | input | 1 | Write response valid |
| mem_babort | input | 1 | Write response reports a synchronous abort |
| wb_valid | output | 1 | Destination write-back strobe |
| wb_idx | output | 4 | Destination register index |
| wb_data | output | WORD_W | Status, 0 stored / 1 not stored |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Instruction in progress |
| undef_instr | output | 1 | Undefined-instruction report, with done |
| align_fault | output | 1 | Alignment fault report, with done |
| data_abort | output | 1 | Data abort report, with done |

## Verification
The write path is driven in both encodings and both endiannesses, using distinct register contents. This makes a swapped word order or a wrong data-register index show up in `mem_wdata`. The same legal word is then repeated with the monitor failing, with a misaligned base under both monitor verdicts, with an aborting response and with the condition failing. These runs separate the status-1 path, the alignment fault, the abort and the silent skip. A set of words that each break one encoding bit or one register rule targets the legality logic, and one word with two equal data registers must still store. Stall cycles on `mem_wready` test that the request holds, and the cycle distance from acceptance, response and write-back to `done` tests the timing.

// File: rtl/xsd_pkg.sv
package xsd_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 4;

  typedef enum logic [2:0] {ST_IDLE, ST_WRITE, ST_RESP, ST_WB, ST_DONE} xsd_state_e;
  typedef enum logic [2:0] {CL_SKIP, CL_UNDEF, CL_FAIL, CL_ALIGN, CL_WRITE} xsd_class_e;
  typedef enum logic [1:0] {FK_NONE, FK_UNDEF, FK_ALIGN, FK_ABORT} xsd_fin_e;

  typedef struct packed {
    logic [IDX_W-1:0] rd;
    logic [IDX_W-1:0] rt;
    logic [IDX_W-1:0] rt2;
    logic [IDX_W-1:0] rn;
    logic             illegal;
  } xsd_fields_t;
endpackage

// File: rtl/xsd_decode.sv
module xsd_decode
  import xsd_pkg::*;
(
  input  logic [31:0]  instr,
  input  logic         pair_enc,
  output xsd_fields_t  f
);
  localparam logic [IDX_W-1:0] PC_IDX = '1;
  localparam int NSRC = 3;

  xsd_fields_t fx_f, hp_f, sel_f;
  logic fx_ok, hp_ok, fx_pc, hp_pc;
  logic [IDX_W-1:0] src [NSRC];
  logic [NSRC-1:0] clash;

  always_comb begin
    fx_f         = '0;
    fx_f.rn      = instr[19:16];
    fx_f.rd      = instr[15:12];
    fx_f.rt      = instr[3:0];
    fx_f.rt2     = instr[3:0] + IDX_W'(1);
    hp_f         = '0;
    hp_f.rn      = instr[19:16];
    hp_f.rt      = instr[15:12];
    hp_f.rt2     = instr[11:8];
    hp_f.rd      = instr[3:0];
  end

  // fixed-width form: bits 11:10 are left unchecked
  assign fx_ok = (instr[31:28] != 4'hF) && (instr[27:20] == 8'h1A) &&
                 (instr[9:8] == 2'b10) && (instr[7:4] == 4'b1001);
  assign hp_ok = (instr[31:20] == 12'hE8C) && (instr[7:4] == 4'hF);

  assign fx_pc = fx_f.rt[0] || (fx_f.rt2 == PC_IDX) || (fx_f.rd == PC_IDX) ||
                 (fx_f.rn == PC_IDX);
  assign hp_pc = (hp_f.rt == PC_IDX) || (hp_f.rt2 == PC_IDX) ||
                 (hp_f.rd == PC_IDX) || (hp_f.rn == PC_IDX);

  assign sel_f  = pair_enc ? hp_f : fx_f;
  assign src[0] = sel_f.rn;
  assign src[1] = sel_f.rt;
  assign src[2] = sel_f.rt2;

  for (genvar i = 0; i < NSRC; i++) begin : g_clash
    assign clash[i] = (sel_f.rd == src[i]);
  end

  always_comb begin
    f         = sel_f;
    f.illegal = (pair_enc ? (!hp_ok || hp_pc) : (!fx_ok || fx_pc)) || (|clash);
  end
endmodule

// File: rtl/xsd_pack.sv
module xsd_pack #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0]   first_w,
  input  logic [WORD_W-1:0]   second_w,
  input  logic                big,
  output logic [2*WORD_W-1:0] dword
);
  localparam int LANES = 2;

  // lane 0 is the low half of the doubleword
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign dword[l*WORD_W +: WORD_W] = ((l == 0) != big) ? first_w : second_w;
  end
endmodule

// File: rtl/xsd_ctrl.sv
module xsd_ctrl
  import xsd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  xsd_class_e cls,
  input  logic       mem_wready,
  input  logic       mem_bvalid,
  input  logic       mem_babort,
  output logic       idle,
  output logic       mem_wvalid,
  output logic       wb_valid,
  output logic       wb_fail,
  output logic       done,
  output logic       undef_o,
  output logic       align_o,
  output logic       abort_o
);
  xsd_state_e st, st_n;
  xsd_fin_e   fin_q, fin_n;
  logic       fail_q, fail_n;

  always_comb begin
    st_n   = st;
    fin_n  = fin_q;
    fail_n = fail_q;
    unique case (st)
      ST_IDLE: if (accept) begin
        fin_n  = FK_NONE;
        fail_n = 1'b0;
        case (cls)
          CL_SKIP:  st_n = ST_DONE;
          CL_UNDEF: begin st_n = ST_DONE; fin_n = FK_UNDEF; end
          CL_ALIGN: begin st_n = ST_DONE; fin_n = FK_ALIGN; end
          CL_FAIL:  begin st_n = ST_WB;   fail_n = 1'b1;    end
          default:  st_n = ST_WRITE;
        endcase
      end
      ST_WRITE: if (mem_wready) st_n = ST_RESP;
      ST_RESP: if (mem_bvalid) begin
        if (mem_babort) begin
          st_n  = ST_DONE;
          fin_n = FK_ABORT;
        end else begin
          st_n = ST_WB;
        end
      end
      ST_WB:   st_n = ST_DONE;
      ST_DONE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      fin_q  <= FK_NONE;
      fail_q <= 1'b0;
    end else begin
      st     <= st_n;
      fin_q  <= fin_n;
      fail_q <= fail_n;
    end
  end

  assign idle       = (st == ST_IDLE);
  assign mem_wvalid = (st == ST_WRITE);
  assign wb_valid   = (st == ST_WB);
  assign wb_fail    = fail_q;
  assign done       = (st == ST_DONE);
  assign undef_o    = done && (fin_q == FK_UNDEF);
  assign align_o    = done && (fin_q == FK_ALIGN);
  assign abort_o    = done && (fin_q == FK_ABORT);
endmodule

// File: rtl/xstore_dw_unit.sv
module xstore_dw_unit
  import xsd_pkg::*;
#(
  parameter int WORD_W = xsd_pkg::WORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [31:0]         req_instr,
  input  logic                req_pair_enc,
  input  logic                req_cond_pass,
  input  logic                req_big_endian,
  output logic [IDX_W-1:0]    rf_base_idx,
  output logic [IDX_W-1:0]    rf_lo_idx,
  output logic [IDX_W-1:0]    rf_hi_idx,
  input  logic [WORD_W-1:0]   rf_base_data,
  input  logic [WORD_W-1:0]   rf_lo_data,
  input  logic [WORD_W-1:0]   rf_hi_data,
  input  logic                mon_pass,
  output logic                mem_wvalid,
  input  logic                mem_wready,
  output logic [WORD_W-1:0]   mem_waddr,
  output logic [2*WORD_W-1:0] mem_wdata,
  input  logic                mem_bvalid,
  input  logic                mem_babort,
  output logic                wb_valid,
  output logic [IDX_W-1:0]    wb_idx,
  output logic [WORD_W-1:0]   wb_data,
  output logic                done,
  output logic                busy,
  output logic                undef_instr,
  output logic                align_fault,
  output logic                data_abort
);
  localparam int ALIGN_W = $clog2(WORD_W / 8);

  xsd_fields_t           fld;
  xsd_class_e            cls;
  logic                  accept, idle, misaligned, wb_fail;
  logic [2*WORD_W-1:0]   dword_n, data_q;
  logic [WORD_W-1:0]     addr_q;
  logic [IDX_W-1:0]      rd_q;

  xsd_decode u_dec (
    .instr    (req_instr),
    .pair_enc (req_pair_enc),
    .f        (fld)
  );

  assign rf_base_idx = fld.rn;
  assign rf_lo_idx   = fld.rt;
  assign rf_hi_idx   = fld.rt2;

  xsd_pack #(.WORD_W(WORD_W)) u_pack (
    .first_w  (rf_lo_data),
    .second_w (rf_hi_data),
    .big      (req_big_endian),
    .dword    (dword_n)
  );

  assign req_ready  = idle;
  assign accept     = req_valid && idle;
  assign misaligned = |rf_base_data[ALIGN_W-1:0];

  // outcome priority: condition, legality, monitor verdict, alignment
  always_comb begin
    if (!req_cond_pass)    cls = CL_SKIP;
    else if (fld.illegal)  cls = CL_UNDEF;
    else if (!mon_pass)    cls = CL_FAIL;
    else if (misaligned)   cls = CL_ALIGN;
    else                   cls = CL_WRITE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      rd_q   <= fld.rd;
      addr_q <= rf_base_data;
      data_q <= dword_n;
    end
  end

  xsd_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .cls        (cls),
    .mem_wready (mem_wready),
    .mem_bvalid (mem_bvalid),
    .mem_babort (mem_babort),
    .idle       (idle),
    .mem_wvalid (mem_wvalid),
    .wb_valid   (wb_valid),
    .wb_fail    (wb_fail),
    .done       (done),
    .undef_o    (undef_instr),
    .align_o    (align_fault),
    .abort_o    (data_abort)
  );

  assign mem_waddr = addr_q;
  assign mem_wdata = data_q;
  assign wb_idx    = rd_q;
  assign wb_data   = {{(WORD_W-1){1'b0}}, wb_fail};
  assign busy      = !idle;
endmodule

// File: rtl/xstore_dw_chk.sv
module xstore_dw_chk #(
  parameter int WORD_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_ready,
  input logic                mem_wvalid,
  input logic                mem_wready,
  input logic [WORD_W-1:0]   mem_waddr,
  input logic [2*WORD_W-1:0] mem_wdata,
  input logic                wb_valid,
  input logic [WORD_W-1:0]   wb_data,
  input logic                done,
  input logic                undef_instr,
  input logic                align_fault,
  input logic                data_abort
);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid && !mem_wready |=> mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata));

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_wvalid && !wb_valid);

  assert_wb_then_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> done && !wb_valid);

  assert_done_to_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);

  assert_status_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_data[WORD_W-1:1] == '0));

  assert_flag_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (undef_instr || align_fault || data_abort) |-> done && !wb_valid && !mem_wvalid);

  assert_single_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({undef_instr, align_fault, data_abort}));
endmodule

bind xstore_dw_unit xstore_dw_chk #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .mem_wvalid  (mem_wvalid),
  .mem_wready  (mem_wready),
  .mem_waddr   (mem_waddr),
  .mem_wdata   (mem_wdata),
  .wb_valid    (wb_valid),
  .wb_data     (wb_data),
  .done        (done),
  .undef_instr (undef_instr),
  .align_fault (align_fault),
  .data_abort  (data_abort)
);

// File: tb/xstore_dw_unit_tb.sv
module xstore_dw_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_ready, req_pair_enc = 0, req_cond_pass = 1, req_big_endian = 0;
  logic [31:0] req_instr = '0;
  logic [3:0]  rf_base_idx, rf_lo_idx, rf_hi_idx, wb_idx;
  logic [31:0] rf_base_data, rf_lo_data, rf_hi_data, mem_waddr, wb_data;
  logic        mon_pass = 1, mem_wvalid, mem_wready = 0, mem_bvalid = 0, mem_babort = 0;
  logic [63:0] mem_wdata;
  logic        wb_valid, done, busy, undef_instr, align_fault, data_abort;

  logic [31:0] regs [16];
  assign rf_base_data = regs[rf_base_idx];
  assign rf_lo_data   = regs[rf_lo_idx];
  assign rf_hi_data   = regs[rf_hi_idx];

  xstore_dw_unit u_dut (.*);

  int compared = 0, mismatched = 0, cyc = 0, acc_cyc = 0, stall_n = 0, stall_cnt = 0;
  logic abort_mode = 0, hs_q = 0, bv_prev = 0, wb_prev = 0, done_seen = 0, finished = 0;
  string cur_tag = "";

  logic [95:0] mem_q [$];   // {addr, data}
  logic [35:0] wb_q [$];    // {idx, value}
  int          kind_q [$];
  int          lat_q [$];
  logic        hwb_q [$];

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) hs_q <= mem_wvalid && mem_wready;

  // memory responder
  always @(negedge clk) begin
    mem_bvalid = hs_q;
    mem_babort = hs_q && abort_mode;
    if (mem_wvalid) begin
      if (stall_cnt < stall_n) begin mem_wready = 1'b0; stall_cnt++; end
      else mem_wready = 1'b1;
    end else begin
      mem_wready = 1'b0;
      stall_cnt  = 0;
    end
  end

  task automatic chk(input string what, input logic [95:0] act, input logic [95:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", cur_tag, what, act, exp);
    end
  endtask

  // monitor: samples 2 ns after the falling edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (mem_wvalid && mem_wready) begin
        if (mem_q.size() == 0) chk("unexpected write", 96'd1, 96'd0);
        else chk("write addr/data", {mem_waddr, mem_wdata}, mem_q.pop_front());
      end
      if (wb_valid) begin
        if (wb_q.size() == 0) chk("unexpected write-back", 96'd1, 96'd0);
        else begin
          chk("write-back idx/status", {60'd0, wb_idx, wb_data}, {60'd0, wb_q.pop_front()});
          if (wb_data == 32'd0) chk("R12 wb after response", {95'd0, bv_prev}, 96'd1);
        end
      end
      if (done) begin
        if (kind_q.size() == 0) chk("unexpected done", 96'd1, 96'd0);
        else begin
          int k, l;
          logic hw;
          logic [2:0] ev;
          k = kind_q.pop_front();
          l = lat_q.pop_front();
          hw = hwb_q.pop_front();
          ev = (k == 1) ? 3'b100 : (k == 2) ? 3'b010 : (k == 3) ? 3'b001 : 3'b000;
          chk("flags undef/align/abort", {93'd0, undef_instr, align_fault, data_abort}, {93'd0, ev});
          chk("R12 done after wb", {95'd0, wb_prev}, {95'd0, hw});
          if (l >= 0) chk("latency", 96'(cyc - acc_cyc), 96'(l));
        end
        done_seen = 1'b1;
      end
      bv_prev = mem_bvalid;
      wb_prev = wb_valid;
    end
  end

  function automatic logic [31:0] fx(input logic [3:0] cnd, input logic [3:0] rn,
      input logic [3:0] rd, input logic [7:0] mid, input logic [3:0] rt);
    return {cnd, 8'h1A, rn, rd, mid, rt};
  endfunction

  function automatic logic [31:0] hp(input logic [3:0] rn, input logic [3:0] rt,
      input logic [3:0] rt2, input logic [3:0] nib, input logic [3:0] rd);
    return {12'hE8C, rn, rt, rt2, nib, rd};
  endfunction

  task automatic run(input string tag, input logic [31:0] instr, input logic pair,
      input logic cnd, input logic big, input logic mon, input logic abrt, input int stall,
      input int kind, input int lat, input logic has_mem, input logic [31:0] eaddr,
      input logic [63:0] edata, input logic has_wb, input logic [3:0] widx,
      input logic [31:0] wval);
    @(negedge clk);
    abort_mode = abrt;
    stall_n    = stall;
    if (has_mem) mem_q.push_back({eaddr, edata});
    if (has_wb)  wb_q.push_back({widx, wval});
    kind_q.push_back(kind);
    lat_q.push_back(lat);
    hwb_q.push_back(has_wb);
    cur_tag        = tag;
    acc_cyc        = cyc + 1;
    req_instr      = instr;
    req_pair_enc   = pair;
    req_cond_pass  = cnd;
    req_big_endian = big;
    mon_pass       = mon;
    req_valid      = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done_seen) @(negedge clk);
    done_seen = 1'b0;
  endtask

  localparam logic [7:0] MID = 8'hE9;

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'hC0DE_0000 + 32'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_tag = "R11 reset";
    chk("ready/wvalid/wb/done/busy", {91'd0, req_ready, mem_wvalid, wb_valid, done, busy},
        {91'd0, 5'b10000});

    regs[2] = 32'h0000_1000;
    run("R7 R6 R1 LE pass", fx(4'hE, 2, 0, MID, 4), 0, 1, 0, 1, 0, 0, 0, -1,
        1, 32'h1000, {32'hC0DE0005, 32'hC0DE0004}, 1, 0, 0);
    regs[1] = 32'h0000_2008;
    run("R2 R6 R11 BE stall", hp(1, 6, 9, 4'hF, 3), 1, 1, 1, 1, 0, 2, 0, -1,
        1, 32'h2008, {32'hC0DE0006, 32'hC0DE0009}, 1, 3, 0);
    run("R7 R12 monitor fail", fx(4'hE, 2, 0, MID, 4), 0, 1, 0, 0, 0, 0, 0, 1,
        0, 0, 0, 1, 0, 1);
    regs[2] = 32'h0000_1002;
    run("R8 misaligned pass", fx(4'hE, 2, 0, MID, 4), 0, 1, 0, 1, 0, 0, 2, 0,
        0, 0, 0, 0, 0, 0);
    run("R8 misaligned fail", fx(4'hE, 2, 0, MID, 4), 0, 1, 0, 0, 0, 0, 0, 1,
        0, 0, 0, 1, 0, 1);
    regs[2] = 32'h0000_1010;
    run("R9 abort", fx(4'hE, 2, 0, MID, 4), 0, 1, 0, 1, 1, 1, 3, -1,
        1, 32'h1010, {32'hC0DE0005, 32'hC0DE0004}, 0, 0, 0);
    run("R10 cond fail", fx(4'hE, 2, 0, MID, 4), 0, 0, 0, 1, 0, 0, 0, 0,
        0, 0, 0, 0, 0, 0);
    run("R10 cond fail illegal", fx(4'hE, 2, 0, MID, 5), 0, 0, 0, 1, 0, 0, 0, 0,
        0, 0, 0, 0, 0, 0);
    run("R3 R5 odd rt", fx(4'hE, 2, 0, MID, 5), 0, 1, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    run("R3 rt 14", fx(4'hE, 2, 0, MID, 14), 0, 1, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    run("R3 rd 15", fx(4'hE, 2, 15, MID, 4), 0, 1, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    run("R3 rn 15", fx(4'hE, 15, 0, MID, 4), 0, 1, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    run("R4 rd eq rn", fx(4'hE, 2, 2, MID, 4), 0, 1, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    run("R4 rd eq rt2", fx(4'hE, 2, 5, MID, 4), 0, 1, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    run("R4 pair rt2 15", hp(1, 6, 15, 4'hF, 3), 1, 1, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    run("R4 pair rn 15", hp(15, 6, 9, 4'hF, 3), 1, 1, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    run("R4 pair rd eq rt", hp(1, 6, 9, 4'hF, 6), 1, 1, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    run("R1 cond field F", fx(4'hF, 2, 0, MID, 4), 0, 1, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    run("R1 bad bits 7:4", fx(4'hE, 2, 0, 8'hE8, 4), 0, 1, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    run("R2 bad bits 7:4", hp(1, 6, 9, 4'hE, 3), 1, 1, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    regs[2] = 32'h0000_3000;
    run("R1 bits 11:10 ignored", fx(4'h0, 2, 0, 8'h29, 4), 0, 1, 0, 1, 0, 0, 0, -1,
        1, 32'h3000, {32'hC0DE0005, 32'hC0DE0004}, 1, 0, 0);
    run("R4 equal data regs", hp(1, 7, 7, 4'hF, 3), 1, 1, 0, 1, 0, 1, 0, -1,
        1, 32'h2008, {32'hC0DE0007, 32'hC0DE0007}, 1, 3, 0);

    repeat (3) @(negedge clk);
    cur_tag = "R12 queues";
    chk("leftover expectations", 96'(mem_q.size() + wb_q.size() + kind_q.size()), 96'd0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL %s watchdog actual=timeout expected=done", cur_tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule